// File: doc/BRIEF.md
# SHA-512 Family Hash Engine

This block hashes message blocks that software has already padded, each 1024 bits wide, and produces a digest from the SHA-512 family. One datapath serves four output variants. They differ only in the starting hash words and in how many of the leftmost digest bits are kept: SHA-512/224, SHA-512/256, SHA-384 and SHA-512. The engine runs one compression round per clock. The message schedule lives in a window of sixteen 64-bit words that slides by one word each round.

Software reaches the engine through a small register map. It writes the sixteen block words and the variant code. It then sets a start flag: begin-message for the first block, or continue-chain for each block after it. Both flags drop by themselves one cycle after they are written, so every block needs a fresh write. Completion is shown by a ready line and a digest-valid line, and these are mirrored in a status register. The digest is read back as eight 64-bit words, the leftmost word first.

Top module: `hash512_top`

## Requirements
- R1: While reset is held and straight after it is released, ready is 1, digest_valid is 0, both start flags read 0, and all eight digest words read 0.
- R2: Variant code 3 (SHA-512) on a begin-message command yields the full 512-bit digest, with word 0 (address 0x20) holding bits 511:448.
- R3: Variant code 2 (SHA-384) keeps the leftmost 384 digest bits and returns zeros in digest words 6 and 7.
- R4: Variant code 1 (SHA-512/256) keeps the leftmost 256 bits. Variant code 0 (SHA-512/224) keeps the leftmost 224 bits, so the low 32 bits of word 3 and words 4 to 7 read zero.
- R5: A continue-chain command (control bit 1) after a begin-message command (control bit 0) hashes a second block on top of the first block's state, so two-block messages give the correct digest.
- R6: The variant code is captured only when a begin-message command is accepted. Rewriting the variant register before a continue-chain command changes neither the result nor its truncation.
- R7: After the control write edge, ready is low from the next edge on. Ready and digest_valid both rise exactly 82 clock edges after the write edge, and the engine never starts without a command.
- R8: Each start flag reads 1 in the cycle after it is written and reads 0 one cycle later, with no further write.
- R9: A start command written while the engine is busy is dropped. The run in progress finishes on schedule with its own result, and no second run follows.
- R10: digest_valid goes low as soon as a new block is accepted and is never high while ready is low.
- R11: The digest output stays unchanged for the whole of a run and is only replaced when the run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register access select |
| we | input | 1 | Write enable, qualified by cs |
| addr | input | 6 | Register address: 0x00 control, 0x01 variant, 0x02 status, 0x10-0x1F block words (0x10 leftmost), 0x20-0x27 digest words |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, decoded combinationally from addr |
| ready | output | 1 | Engine idle and able to take a command |
| digest_valid | output | 1 | Digest register holds a finished result |

## Verification
A write to the control register lands on edge W. The flag reads back set at the following falling edge, and both the flag and ready read low one edge later. The finished digest and the rise of ready and digest_valid are due at edge W+82. Every start command records W together with its expected digest in a scoreboard queue. A monitor watches for the rising edge of digest_valid on falling clock edges and compares the edge count against W+82 before the driver reads the digest words. Busy-time reads and dropped commands are checked at fixed falling edges within that window.

// File: rtl/hash512_pkg.sv
package hash512_pkg;

  localparam int WORD_W = 64;
  localparam int NWORD  = 8;
  localparam int WIN    = 16;
  localparam int ROUNDS = 80;
  localparam int BLK_W  = WIN * WORD_W;
  localparam int DIG_W  = NWORD * WORD_W;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam int TAP_S1 = WIN - 2;
  localparam int TAP_AD = WIN - 7;
  localparam int TAP_S0 = 1;

  typedef enum logic [1:0] {
    VAR_T224 = 2'd0,
    VAR_T256 = 2'd1,
    VAR_W384 = 2'd2,
    VAR_F512 = 2'd3
  } variant_e;

  function automatic logic [63:0] rotr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] big_s0(input logic [63:0] x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic logic [63:0] big_s1(input logic [63:0] x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic logic [63:0] sm_s0(input logic [63:0] x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [63:0] sm_s1(input logic [63:0] x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic logic [63:0] choose(input logic [63:0] e, input logic [63:0] f,
                                         input logic [63:0] g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [63:0] major(input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  // starting hash word i for a variant
  function automatic logic [63:0] start_word(input logic [1:0] v, input int i);
    logic [511:0] s;
    case (v)
      VAR_T224: s = 512'h8c3d37c819544da273e1996689dcd4d61dfab7ae32ff9c82679dd514582f9fcf0f6d2b697bd44da877e36f7304c489423f9d85a86a1d36c81112e6ad91d692a1;
      VAR_T256: s = 512'h22312194fc2bf72c9f555fa3c84c64c22393b86b6f53b151963877195940eabd96283ee2a88effe3be5e1e25538639922b0199fc2c85b8aa0eb72ddc81c52ca2;
      VAR_W384: s = 512'hcbbb9d5dc1059ed8629a292a367cd5079159015a3070dd17152fecd8f70e593967332667ffc00b318eb44a8768581511db0c2e0d64f98fa747b5481dbefa4fa4;
      default:  s = 512'h6a09e667f3bcc908bb67ae8584caa73b3c6ef372fe94f82ba54ff53a5f1d36f1510e527fade682d19b05688c2b3e6c1f1f83d9abfb41bd6b5be0cd19137e2179;
    endcase
    return s[511 - 64*i -: 64];
  endfunction

  function automatic int keep_bits(input logic [1:0] v);
    case (v)
      VAR_T224: return 224;
      VAR_T256: return 256;
      VAR_W384: return 384;
      default:  return 512;
    endcase
  endfunction

  // round constant n: low 64 bits of floor(cbrt(p_n) * 2^64), p_n the n-th prime
  function automatic logic [63:0] round_const(input int n);
    int found;
    int prime;
    bit is_p;
    logic [255:0] target;
    logic [255:0] root;
    logic [255:0] cand;
    found = 0;
    prime = 2;
    for (int c = 2; c < 420; c++) begin
      is_p = 1'b1;
      for (int d = 2; d < 21; d++) begin
        if (d < c && (c % d) == 0) is_p = 1'b0;
      end
      if (is_p) begin
        if (found == n) prime = c;
        found++;
      end
    end
    target = 256'(prime) << 192;
    root   = '0;
    for (int b = 70; b >= 0; b--) begin
      cand = root | (256'(1) << b);
      if (cand * cand * cand <= target) root = cand;
    end
    return root[63:0];
  endfunction

endpackage

// File: rtl/hash512_kconst.sv
module hash512_kconst
  import hash512_pkg::*;
(
  input  logic [RND_W-1:0]  idx,
  output logic [WORD_W-1:0] kval
);

  logic [ROUNDS-1:0][WORD_W-1:0] table_w;

  for (genvar g = 0; g < ROUNDS; g++) begin : g_const
    localparam logic [WORD_W-1:0] KG = round_const(g);
    assign table_w[g] = KG;
  end

  assign kval = (idx < RND_W'(ROUNDS)) ? table_w[idx] : '0;

endmodule

// File: rtl/hash512_sched.sv
module hash512_sched
  import hash512_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BLK_W-1:0]  block,
  output logic [WORD_W-1:0] w_cur
);

  logic [WIN-1:0][WORD_W-1:0] win_q;
  logic [WIN-1:0][WORD_W-1:0] win_d;
  logic [WORD_W-1:0]          w_new;

  // word j of the window holds W[t+j] during round t
  assign w_new = sm_s1(win_q[TAP_S1]) + win_q[TAP_AD] + sm_s0(win_q[TAP_S0]) + win_q[0];
  assign w_cur = win_q[0];

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    if (g == WIN - 1) begin : g_tail
      assign win_d[g] = load  ? block[BLK_W-1-WORD_W*g -: WORD_W] :
                        shift ? w_new : win_q[g];
    end else begin : g_body
      assign win_d[g] = load  ? block[BLK_W-1-WORD_W*g -: WORD_W] :
                        shift ? win_q[g+1] : win_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (load || shift) begin
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/hash512_core.sv
module hash512_core
  import hash512_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_init,
  input  logic             start_next,
  input  logic [1:0]       mode,
  input  logic [BLK_W-1:0] block,
  output logic             ready,
  output logic             digest_valid,
  output logic [DIG_W-1:0] digest
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD} st_e;

  st_e               st_q, st_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;
  logic [WORD_W-1:0] hv_q [NWORD];
  logic [WORD_W-1:0] hv_d [NWORD];
  logic [WORD_W-1:0] wv_q [NWORD];
  logic [WORD_W-1:0] wv_d [NWORD];
  logic [1:0]        mode_q, mode_d;
  logic [1:0]        omode_q, omode_d;
  logic              first_q, first_d;
  logic              valid_q, valid_d;

  logic              accept;
  logic              run_en;
  logic              fold_en;
  logic [WORD_W-1:0] w_cur;
  logic [WORD_W-1:0] k_cur;
  logic [WORD_W-1:0] t1, t2;
  logic [DIG_W-1:0]  flat;
  logic [DIG_W-1:0]  keep_mask;

  assign accept  = (st_q == ST_IDLE) && (start_init || start_next);
  assign run_en  = (st_q == ST_RUN);
  assign fold_en = (st_q == ST_FOLD);

  hash512_sched sched_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .shift (run_en),
    .block (block),
    .w_cur (w_cur)
  );

  hash512_kconst kconst_i (
    .idx  (rnd_q),
    .kval (k_cur)
  );

  assign t1 = wv_q[7] + big_s1(wv_q[4]) + choose(wv_q[4], wv_q[5], wv_q[6]) + k_cur + w_cur;
  assign t2 = big_s0(wv_q[0]) + major(wv_q[0], wv_q[1], wv_q[2]);

  always_comb begin
    st_d    = st_q;
    rnd_d   = rnd_q;
    mode_d  = mode_q;
    omode_d = omode_q;
    first_d = first_q;
    valid_d = valid_q;
    for (int i = 0; i < NWORD; i++) begin
      hv_d[i] = hv_q[i];
      wv_d[i] = wv_q[i];
    end
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_RUN;
          rnd_d   = '0;
          valid_d = 1'b0;
          if (start_init) begin
            mode_d  = mode;
            first_d = 1'b1;
            for (int i = 0; i < NWORD; i++) wv_d[i] = start_word(mode, i);
          end else begin
            first_d = 1'b0;
            for (int i = 0; i < NWORD; i++) wv_d[i] = hv_q[i];
          end
        end
      end
      ST_RUN: begin
        wv_d[0] = t1 + t2;
        wv_d[1] = wv_q[0];
        wv_d[2] = wv_q[1];
        wv_d[3] = wv_q[2];
        wv_d[4] = wv_q[3] + t1;
        wv_d[5] = wv_q[4];
        wv_d[6] = wv_q[5];
        wv_d[7] = wv_q[6];
        rnd_d   = rnd_q + RND_W'(1);
        if (rnd_q == RND_W'(ROUNDS - 1)) st_d = ST_FOLD;
      end
      ST_FOLD: begin
        for (int i = 0; i < NWORD; i++) begin
          hv_d[i] = (first_q ? start_word(mode_q, i) : hv_q[i]) + wv_q[i];
        end
        omode_d = mode_q;
        valid_d = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rnd_q   <= '0;
      mode_q  <= VAR_F512;
      omode_q <= VAR_F512;
      first_q <= 1'b0;
      valid_q <= 1'b0;
      for (int i = 0; i < NWORD; i++) begin
        hv_q[i] <= '0;
        wv_q[i] <= '0;
      end
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      if (accept || run_en) rnd_q <= rnd_d;
      if (accept) begin
        mode_q  <= mode_d;
        first_q <= first_d;
      end
      if (accept || run_en) begin
        for (int i = 0; i < NWORD; i++) wv_q[i] <= wv_d[i];
      end
      if (fold_en) begin
        omode_q <= omode_d;
        for (int i = 0; i < NWORD; i++) hv_q[i] <= hv_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NWORD; i++) flat[DIG_W-1-WORD_W*i -: WORD_W] = hv_q[i];
  end

  assign keep_mask    = ~({DIG_W{1'b1}} >> keep_bits(omode_q));
  assign digest       = flat & keep_mask;
  assign ready        = (st_q == ST_IDLE);
  assign digest_valid = valid_q;

endmodule

// File: rtl/hash512_top.sv
module hash512_top
  import hash512_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  output logic              ready,
  output logic              digest_valid
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] A_BLK  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_DIG  = ADDR_W'(8'h20);

  logic                       wr;
  logic                       init_q, init_d;
  logic                       next_q, next_d;
  logic [1:0]                 mode_q, mode_d;
  logic [WIN-1:0][WORD_W-1:0] blk_q;
  logic [WIN-1:0][WORD_W-1:0] blk_d;
  logic [WIN-1:0]             blk_en;
  logic [DIG_W-1:0]           digest_w;

  assign wr = cs && we;

  always_comb begin
    init_d = wr && (addr == A_CTRL) && wdata[0];
    next_d = wr && (addr == A_CTRL) && wdata[1];
    mode_d = (wr && addr == A_MODE) ? wdata[1:0] : mode_q;
  end

  // block word i (address A_BLK+i) is bits from the top: stored at slot WIN-1-i
  for (genvar g = 0; g < WIN; g++) begin : g_blk
    assign blk_en[WIN-1-g] = wr && (addr == A_BLK + ADDR_W'(g));
    assign blk_d[WIN-1-g]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      next_q <= 1'b0;
      mode_q <= VAR_F512;
      blk_q  <= '0;
    end else begin
      init_q <= init_d;
      next_q <= next_d;
      mode_q <= mode_d;
      for (int i = 0; i < WIN; i++) begin
        if (blk_en[i]) blk_q[i] <= blk_d[i];
      end
    end
  end

  hash512_core core_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_init   (init_q),
    .start_next   (next_q),
    .mode         (mode_q),
    .block        (blk_q),
    .ready        (ready),
    .digest_valid (digest_valid),
    .digest       (digest_w)
  );

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata = {62'd0, next_q, init_q};
    end else if (addr == A_MODE) begin
      rdata = {62'd0, mode_q};
    end else if (addr == A_STAT) begin
      rdata = {62'd0, digest_valid, ready};
    end else begin
      for (int i = 0; i < WIN; i++) begin
        if (addr == A_BLK + ADDR_W'(i)) rdata = blk_q[WIN-1-i];
      end
      for (int i = 0; i < NWORD; i++) begin
        if (addr == A_DIG + ADDR_W'(i)) rdata = digest_w[DIG_W-1-WORD_W*i -: WORD_W];
      end
    end
  end

endmodule

// File: rtl/hash512_chk.sv
module hash512_chk
  import hash512_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              digest_valid,
  input logic              init_flag,
  input logic              next_flag,
  input logic [DIG_W-1:0]  digest
);

  logic       ctrl_wr;
  logic [7:0] busy_cnt;

  assign ctrl_wr = cs && we && (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (ready) busy_cnt <= '0;
    else busy_cnt <= busy_cnt + 8'd1;
  end

  assert_run_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == 8'(ROUNDS + 1));

  assert_no_self_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !init_flag && !next_flag) |=> ready);

  assert_init_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_flag && !ctrl_wr) |=> !init_flag);

  assert_next_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (next_flag && !ctrl_wr) |=> !next_flag);

  assert_start_drops_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (init_flag || next_flag)) |=> (!ready && !digest_valid));

  assert_valid_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |-> ready);

  assert_digest_held_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(digest));

endmodule

bind hash512_top hash512_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs           (cs),
  .we           (we),
  .addr         (addr),
  .ready        (ready),
  .digest_valid (digest_valid),
  .init_flag    (init_q),
  .next_flag    (next_q),
  .digest       (digest_w)
);

// File: tb/hash512_top_tb_top.sv
`timescale 1ns/1ps
module hash512_top_tb_top;

  localparam int LAT = 82;

  logic        clk;
  logic        rst_n;
  logic        cs;
  logic        we;
  logic [5:0]  addr;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        ready;
  logic        digest_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int done_cnt = 0;

  typedef struct {
    logic [511:0] exp;
    int           due;
    bit           chk;
    string        tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t last_item;

  hash512_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs           (cs),
    .we           (we),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .ready        (ready),
    .digest_valid (digest_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [63:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic load_block(input logic [1023:0] b);
    for (int i = 0; i < 16; i++) bus_wr(6'h10 + 6'(i), b[1023-64*i -: 64]);
  endtask

  // issue a start command and queue the expected result
  task automatic launch(input logic [1:0] bits, input logic [511:0] exp,
                        input bit chk, input string tag);
    sb_item_t it;
    logic [63:0] v;
    bus_wr(6'h00, {62'd0, bits});
    it.exp = exp; it.due = cyc + LAT; it.chk = chk; it.tag = tag;
    sb_q.push_back(it);
    bus_rd(6'h00, v);
    check(v[1:0] == bits, "R8", "flag set after write", v, {62'd0, bits});
    @(negedge clk);
    bus_rd(6'h00, v);
    check(v[1:0] == 2'b00, "R8", "flag self-cleared", v, 64'd0);
    bus_rd(6'h02, v);
    check(v[1:0] == 2'b00, "R10", "ready and valid low once started", v, 64'd0);
  endtask

  task automatic collect(input int want);
    logic [63:0] v;
    while (done_cnt < want) @(negedge clk);
    if (last_item.chk) begin
      for (int i = 0; i < 8; i++) begin
        bus_rd(6'h20 + 6'(i), v);
        check(v == last_item.exp[511-64*i -: 64], last_item.tag, "digest word", v,
              last_item.exp[511-64*i -: 64]);
      end
    end
  endtask

  // monitor: pops the scoreboard on each completion and checks its timing
  logic vprev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (digest_valid && !vprev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected completion", 64'd1, 64'd0);
        end else begin
          last_item = sb_q.pop_front();
          check(cyc == last_item.due, "R7", "completion cycle", 64'(cyc), 64'(last_item.due));
          check(ready, "R7", "ready at completion", {63'd0, ready}, 64'd1);
          done_cnt++;
        end
      end
      vprev = digest_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  localparam logic [511:0] E512 = 512'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f;
  localparam logic [511:0] E384 = {384'hcb00753f45a35e8bb5a03d699ac65007272c32ab0eded1631a8b605a43ff5bed8086072ba1e7cc2358baeca134c825a7, 128'h0};
  localparam logic [511:0] E256 = {256'h53048e2681941ef99b2e29b76b4c7dabe4c2d0c634fc6d46e0e2f13107e7af23, 256'h0};
  localparam logic [511:0] E224 = {224'h4634270f707b6a54daae7530460842e20e37ed265ceee9a43e8924aa, 288'h0};
  localparam logic [511:0] E2B  = 512'h8e959b75dae313da8cf4f72814fc143f8f7779c6eb9f7fa17299aeadb6889018501d289e4900f7e4331b99dec4b5433ac7d329eeb6dd26545e96e55b874be909;

  initial begin
    logic [1023:0] abc;
    logic [1023:0] b1;
    logic [1023:0] b2;
    logic [7:0]    by [256];
    logic [63:0]   v;

    cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;

    abc = '0;
    abc[1023:1000] = 24'h616263;
    abc[999:992]   = 8'h80;
    abc[7:0]       = 8'h18;

    for (int j = 0; j < 256; j++) by[j] = 8'h00;
    for (int i = 0; i < 14; i++)
      for (int k = 0; k < 8; k++) by[8*i+k] = 8'h61 + 8'(i + k);
    by[112] = 8'h80;
    by[254] = 8'h03;
    by[255] = 8'h80;
    for (int j = 0; j < 128; j++) begin
      b1[1023-8*j -: 8] = by[j];
      b2[1023-8*j -: 8] = by[128+j];
    end

    repeat (3) @(negedge clk);
    bus_rd(6'h02, v);
    check(v[1:0] == 2'b01, "R1", "status in reset", v, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(6'h02, v);
    check(v[1:0] == 2'b01, "R1", "status after reset", v, 64'd1);
    bus_rd(6'h00, v);
    check(v == 64'd0, "R1", "flags after reset", v, 64'd0);
    for (int i = 0; i < 8; i++) begin
      bus_rd(6'h20 + 6'(i), v);
      check(v == 64'd0, "R1", "digest after reset", v, 64'd0);
    end

    // R2: full-width variant
    load_block(abc);
    bus_wr(6'h01, 64'd3);
    launch(2'b01, E512, 1'b1, "R2");
    collect(1);

    // R3: 384-bit variant
    bus_wr(6'h01, 64'd2);
    launch(2'b01, E384, 1'b1, "R3");
    collect(2);

    // R4: 256-bit and 224-bit truncated variants
    bus_wr(6'h01, 64'd1);
    launch(2'b01, E256, 1'b1, "R4");
    collect(3);
    bus_wr(6'h01, 64'd0);
    launch(2'b01, E224, 1'b1, "R4");
    collect(4);

    // R9 and R11: busy-time commands dropped, digest held
    bus_wr(6'h01, 64'd3);
    launch(2'b01, E512, 1'b1, "R9");
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      bus_rd(6'h20 + 6'(i), v);
      check(v == E224[511-64*i -: 64], "R11", "digest held while busy", v, E224[511-64*i -: 64]);
    end
    bus_wr(6'h01, 64'd0);
    bus_wr(6'h00, 64'd1);
    bus_wr(6'h00, 64'd2);
    collect(5);
    repeat (4) @(negedge clk);
    bus_rd(6'h02, v);
    check(v[1:0] == 2'b11, "R9", "no second run after dropped commands", v, 64'd3);

    // R5 and R6: two-block chain, variant rewritten before the second block
    bus_wr(6'h01, 64'd3);
    load_block(b1);
    launch(2'b01, '0, 1'b0, "R5");
    collect(6);
    bus_wr(6'h01, 64'd0);
    load_block(b2);
    launch(2'b10, E2B, 1'b1, "R6");
    collect(7);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule